// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional jump in a small sequencer is taken. Each request carries two 16-bit operands, a 5-bit condition code, a shift amount and a mask length for the bit-field tests, and a selector that picks one line out of a bank of external condition inputs. One clock edge after a request, the block presents a single taken bit with a matching valid flag. It does not compute a target address and does not update a program counter.

The tests cover the following:
- bitwise intersection of the operands;
- all of B's bits also set in A;
- equality;
- signed and unsigned ordering;
- a zero check on a field cut from the 32-bit pair {B, A};
- the level of one external line.

Each test has a negated twin. The least significant bit of the condition code selects that negation.

Top module: `branch_cond_eval`

## Requirements
- R1: Code 0x00 is always taken and code 0x01 is never taken.
- R2: Code 0x02 is taken when (A & B) is nonzero. Code 0x03 is taken when (A & B) is zero.
- R3: Code 0x04 is taken when (A & B) == B. Code 0x05 is taken when (A & B) != B.
- R4: Code 0x06 is taken when A == B. Code 0x07 is taken when A != B.
- R5: With both operands read as 16-bit two's complement values, the signed codes behave as follows. Code 0x08 is taken when A < B and code 0x09 when A >= B. Code 0x0A is taken when A > B and code 0x0B when A <= B.
- R6: With both operands read as unsigned values, the unsigned codes behave as follows. Code 0x0C is taken when A < B and code 0x0D when A >= B. Code 0x0E is taken when A > B and code 0x0F when A <= B.
- R7: The field is the low 16 bits of ({B, A} >> shift), ANDed with a mask of (maskBits + 1) low ones. Code 0x10 is taken when the field is zero and code 0x11 when it is nonzero.
- R8: Selector bits [3:0] pick a line and bits [7:4] pick a group. The chosen input is extLines[group*16 + line]. Code 0x12 is taken when that line is 1 and code 0x13 when it is 0.
- R9: A selector group at or above the number of groups reads as a 0 line. Code 0x12 is then not taken and code 0x13 is taken.
- R10: Codes 0x14 through 0x1F are never taken, whatever the operands.
- R11: takenValid equals evalValid delayed by one clock. taken is 0 whenever takenValid is 0. Both outputs are 0 during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evalValid | input | 1 | Request strobe |
| condCode | input | 5 | Condition code |
| opA | input | 16 | Operand A |
| opB | input | 16 | Operand B |
| fieldShift | input | 4 | Right shift applied to {B, A} |
| fieldMaskBits | input | 4 | Mask length minus one |
| extLines | input | 64 | External condition lines, 4 groups of 16 |
| extSel | input | 8 | External line selector |
| takenValid | output | 1 | Result valid, one cycle after the request |
| taken | output | 1 | Jump decision |

## Verification
A wrong decode in the control module selects the wrong flag or drops the negation. Either fault turns the taken bit around on the very next cycle for the affected code pair. The bench therefore drives each code together with its twin, on operands placed so that the two must disagree. Faults in the datapath appear the same cycle at boundary operands: equal values, the sign-bit crossing, the widest and narrowest masks, and the last line of a group.

// File: rtl/bce_pkg.sv
package bce_pkg;

  localparam int CODE_W = 5;

  typedef enum logic [CODE_W-2:0] {
    FAM_ALWAYS = 4'd0,
    FAM_AND    = 4'd1,
    FAM_ALLSET = 4'd2,
    FAM_EQ     = 4'd3,
    FAM_LTS    = 4'd4,
    FAM_GTS    = 4'd5,
    FAM_LTU    = 4'd6,
    FAM_GTU    = 4'd7,
    FAM_FZERO  = 4'd8,
    FAM_EXT    = 4'd9
  } family_e;

  localparam int NUM_FLAGS = 10;

  typedef struct packed {
    logic                 enable;
    logic                 invert;
    logic [NUM_FLAGS-1:0] select;
  } strobes_t;

endpackage

// File: rtl/bce_control.sv
module bce_control
  import bce_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalValid,
  input  logic [CODE_W-1:0] condCode,
  output strobes_t          strobes,
  output logic              takenValid
);

  logic [CODE_W-2:0] family;
  logic              known;

  assign family = condCode[CODE_W-1:1];

  always_comb begin
    strobes = '0;
    known   = 1'b1;
    case (family)
      FAM_ALWAYS: strobes.select[FAM_ALWAYS] = 1'b1;
      FAM_AND:    strobes.select[FAM_AND]    = 1'b1;
      FAM_ALLSET: strobes.select[FAM_ALLSET] = 1'b1;
      FAM_EQ:     strobes.select[FAM_EQ]     = 1'b1;
      FAM_LTS:    strobes.select[FAM_LTS]    = 1'b1;
      FAM_GTS:    strobes.select[FAM_GTS]    = 1'b1;
      FAM_LTU:    strobes.select[FAM_LTU]    = 1'b1;
      FAM_GTU:    strobes.select[FAM_GTU]    = 1'b1;
      FAM_FZERO:  strobes.select[FAM_FZERO]  = 1'b1;
      FAM_EXT:    strobes.select[FAM_EXT]    = 1'b1;
      default:    known = 1'b0;
    endcase
    strobes.invert = known & condCode[0];
    strobes.enable = evalValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) takenValid <= 1'b0;
    else       takenValid <= evalValid;
  end

endmodule

// File: rtl/bce_datapath.sv
module bce_datapath
  import bce_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SHIFT_W    = 4,
  parameter int LINE_W     = 4,
  parameter int EXT_GROUPS = 4,
  parameter int SEL_W      = 8,
  localparam int LINES     = 1 << LINE_W,
  localparam int GRP_W     = SEL_W - LINE_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobes_t                    strobes,
  input  logic [DATA_W-1:0]           opA,
  input  logic [DATA_W-1:0]           opB,
  input  logic [SHIFT_W-1:0]          fieldShift,
  input  logic [SHIFT_W-1:0]          fieldMaskBits,
  input  logic [EXT_GROUPS*LINES-1:0] extLines,
  input  logic [SEL_W-1:0]            extSel,
  output logic                        taken
);

  logic [NUM_FLAGS-1:0]  flags;
  logic [DATA_W-1:0]     andBits;
  logic [2*DATA_W-1:0]   pairShifted;
  logic [DATA_W-1:0]     fieldMask;
  logic [DATA_W-1:0]     fieldBits;
  logic [EXT_GROUPS-1:0] groupHit;
  logic [LINE_W-1:0]     lineIdx;
  logic [GRP_W-1:0]      groupIdx;
  logic                  rawHit;

  assign andBits     = opA & opB;
  assign pairShifted = {opB, opA} >> fieldShift;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      fieldMask[i] = (i <= int'(fieldMaskBits));
    end
  end

  assign fieldBits = pairShifted[DATA_W-1:0] & fieldMask;
  assign lineIdx   = extSel[LINE_W-1:0];
  assign groupIdx  = extSel[SEL_W-1:LINE_W];

  for (genvar g = 0; g < EXT_GROUPS; g++) begin : gGroup
    logic [LINES-1:0] groupLines;
    assign groupLines  = extLines[g*LINES +: LINES];
    assign groupHit[g] = (groupIdx == GRP_W'(g)) && groupLines[lineIdx];
  end

  always_comb begin
    flags             = '0;
    flags[FAM_ALWAYS] = 1'b1;
    flags[FAM_AND]    = |andBits;
    flags[FAM_ALLSET] = (andBits == opB);
    flags[FAM_EQ]     = (opA == opB);
    flags[FAM_LTS]    = ($signed(opA) < $signed(opB));
    flags[FAM_GTS]    = ($signed(opA) > $signed(opB));
    flags[FAM_LTU]    = (opA < opB);
    flags[FAM_GTU]    = (opA > opB);
    flags[FAM_FZERO]  = (fieldBits == '0);
    flags[FAM_EXT]    = |groupHit;
  end

  assign rawHit = |(flags & strobes.select);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               taken <= 1'b0;
    else if (strobes.enable) taken <= rawHit ^ strobes.invert;
    else                     taken <= 1'b0;
  end

endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import bce_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SHIFT_W    = $clog2(DATA_W),
  parameter int LINE_W     = 4,
  parameter int EXT_GROUPS = 4,
  parameter int SEL_W      = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               evalValid,
  input  logic [CODE_W-1:0]                  condCode,
  input  logic [DATA_W-1:0]                  opA,
  input  logic [DATA_W-1:0]                  opB,
  input  logic [SHIFT_W-1:0]                 fieldShift,
  input  logic [SHIFT_W-1:0]                 fieldMaskBits,
  input  logic [EXT_GROUPS*(1<<LINE_W)-1:0]  extLines,
  input  logic [SEL_W-1:0]                   extSel,
  output logic                               takenValid,
  output logic                               taken
);

  strobes_t strobes;

  bce_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .evalValid  (evalValid),
    .condCode   (condCode),
    .strobes    (strobes),
    .takenValid (takenValid)
  );

  bce_datapath #(
    .DATA_W     (DATA_W),
    .SHIFT_W    (SHIFT_W),
    .LINE_W     (LINE_W),
    .EXT_GROUPS (EXT_GROUPS),
    .SEL_W      (SEL_W)
  ) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .opA           (opA),
    .opB           (opB),
    .fieldShift    (fieldShift),
    .fieldMaskBits (fieldMaskBits),
    .extLines      (extLines),
    .extSel        (extSel),
    .taken         (taken)
  );

endmodule

// File: rtl/bce_checker.sv
module bce_checker
  import bce_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              evalValid,
  input logic [CODE_W-1:0] condCode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              takenValid,
  input logic              taken
);

  a_r1_always_taken: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && condCode == 5'h00) |=> (takenValid && taken));

  a_r1_never_taken: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && condCode == 5'h01) |=> !taken);

  a_r2_and_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && condCode == 5'h02) |=> (taken == ($past(opA & opB) != '0)));

  a_r4_equal: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && condCode == 5'h06) |=> (taken == ($past(opA) == $past(opB))));

  a_r5_signed_less: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && condCode == 5'h08) |=> (taken == ($signed($past(opA)) < $signed($past(opB)))));

  a_r10_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && condCode >= 5'h14) |=> !taken);

  a_r11_valid_delay: assert property (@(posedge clk) disable iff (!rstN)
    evalValid |=> takenValid);

  a_r11_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !takenValid |-> !taken);

endmodule

bind branch_cond_eval bce_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .evalValid  (evalValid),
  .condCode   (condCode),
  .opA        (opA),
  .opB        (opB),
  .takenValid (takenValid),
  .taken      (taken)
);

// File: tb/branch_cond_eval_bench.sv
`timescale 1ns/1ps
module branch_cond_eval_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evalValid = 1'b0;
  logic [4:0]  condCode = '0;
  logic [15:0] opA = '0, opB = '0;
  logic [3:0]  fieldShift = '0, fieldMaskBits = '0;
  logic [63:0] extLines = '0;
  logic [7:0]  extSel = '0;
  logic        takenValid, taken;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  branch_cond_eval u_branch_cond_eval (
    .clk(clk), .rstN(rstN), .evalValid(evalValid), .condCode(condCode),
    .opA(opA), .opB(opB), .fieldShift(fieldShift), .fieldMaskBits(fieldMaskBits),
    .extLines(extLines), .extSel(extSel), .takenValid(takenValid), .taken(taken)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic evalOnce(input logic [4:0] code, input logic [15:0] a, input logic [15:0] b,
                          input logic [3:0] sh, input logic [3:0] mb, input logic [7:0] sel,
                          input logic exp, input string req);
    @(negedge clk);
    condCode = code; opA = a; opB = b; fieldShift = sh; fieldMaskBits = mb;
    extSel = sel; evalValid = 1'b1;
    @(negedge clk);
    evalValid = 1'b0;
    check({req, " valid"}, takenValid, 1'b1);
    check(req, taken, exp);
  endtask

  task automatic tReset();
    check("R11 reset valid", takenValid, 1'b0);
    check("R11 reset taken", taken, 1'b0);
  endtask

  task automatic tAlways();
    evalOnce(5'h00, 16'h0000, 16'h0000, 0, 0, 0, 1'b1, "R1 always");
    evalOnce(5'h01, 16'hFFFF, 16'hFFFF, 0, 0, 0, 1'b0, "R1 never");
  endtask

  task automatic tAnd();
    evalOnce(5'h02, 16'h00F0, 16'h0F10, 0, 0, 0, 1'b1, "R2 and hit");
    evalOnce(5'h03, 16'h00F0, 16'h0F10, 0, 0, 0, 1'b0, "R2 nand hit");
    evalOnce(5'h02, 16'h00F0, 16'h0F00, 0, 0, 0, 1'b0, "R2 and miss");
    evalOnce(5'h03, 16'h00F0, 16'h0F00, 0, 0, 0, 1'b1, "R2 nand miss");
  endtask

  task automatic tAllSet();
    evalOnce(5'h04, 16'hFF0F, 16'h0F0F, 0, 0, 0, 1'b1, "R3 allset yes");
    evalOnce(5'h05, 16'hFF0F, 16'h0F0F, 0, 0, 0, 1'b0, "R3 notall yes");
    evalOnce(5'h04, 16'hFF0F, 16'h00F1, 0, 0, 0, 1'b0, "R3 allset partial");
    evalOnce(5'h05, 16'hFF0F, 16'h00F1, 0, 0, 0, 1'b1, "R3 notall partial");
  endtask

  task automatic tEqual();
    evalOnce(5'h06, 16'h1234, 16'h1234, 0, 0, 0, 1'b1, "R4 eq same");
    evalOnce(5'h07, 16'h1234, 16'h1234, 0, 0, 0, 1'b0, "R4 ne same");
    evalOnce(5'h06, 16'h1234, 16'h1235, 0, 0, 0, 1'b0, "R4 eq diff");
    evalOnce(5'h07, 16'h1234, 16'h1235, 0, 0, 0, 1'b1, "R4 ne diff");
  endtask

  task automatic tSigned();
    logic [15:0] av [4] = '{16'hFFFF, 16'h8000, 16'h7FFF, 16'h0005};
    logic [15:0] bv [4] = '{16'h0001, 16'h7FFF, 16'h8000, 16'h0005};
    for (int i = 0; i < 4; i++) begin
      int sa = int'($signed(av[i]));
      int sb = int'($signed(bv[i]));
      evalOnce(5'h08, av[i], bv[i], 0, 0, 0, sa <  sb, "R5 lt signed");
      evalOnce(5'h09, av[i], bv[i], 0, 0, 0, sa >= sb, "R5 ge signed");
      evalOnce(5'h0A, av[i], bv[i], 0, 0, 0, sa >  sb, "R5 gt signed");
      evalOnce(5'h0B, av[i], bv[i], 0, 0, 0, sa <= sb, "R5 le signed");
    end
  endtask

  task automatic tUnsigned();
    logic [15:0] av [4] = '{16'hFFFF, 16'h8000, 16'h7FFF, 16'h0005};
    logic [15:0] bv [4] = '{16'h0001, 16'h7FFF, 16'h8000, 16'h0005};
    for (int i = 0; i < 4; i++) begin
      int ua = int'(av[i]);
      int ub = int'(bv[i]);
      evalOnce(5'h0C, av[i], bv[i], 0, 0, 0, ua <  ub, "R6 lt unsigned");
      evalOnce(5'h0D, av[i], bv[i], 0, 0, 0, ua >= ub, "R6 ge unsigned");
      evalOnce(5'h0E, av[i], bv[i], 0, 0, 0, ua >  ub, "R6 gt unsigned");
      evalOnce(5'h0F, av[i], bv[i], 0, 0, 0, ua <= ub, "R6 le unsigned");
    end
  endtask

  task automatic tField();
    // {B,A} >> 15 = 0x0003, two-bit mask -> 3, nonzero
    evalOnce(5'h10, 16'h8000, 16'h0001, 4'd15, 4'd1, 0, 1'b0, "R7 zero straddle");
    evalOnce(5'h11, 16'h8000, 16'h0001, 4'd15, 4'd1, 0, 1'b1, "R7 nonzero straddle");
    // 15-bit mask hides A[15]
    evalOnce(5'h10, 16'h8000, 16'h0000, 4'd0, 4'd14, 0, 1'b1, "R7 zero mask14");
    evalOnce(5'h10, 16'h8000, 16'h0000, 4'd0, 4'd15, 0, 1'b0, "R7 zero mask15");
    // one-bit mask, shift 4: A[4]
    evalOnce(5'h11, 16'h0020, 16'h0000, 4'd4, 4'd0, 0, 1'b0, "R7 nonzero bit4 clear");
    evalOnce(5'h11, 16'h0010, 16'h0000, 4'd4, 4'd0, 0, 1'b1, "R7 nonzero bit4 set");
  endtask

  task automatic tExt();
    extLines = '0;
    extLines[2*16 + 4]  = 1'b1;
    extLines[3*16 + 15] = 1'b1;
    evalOnce(5'h12, 0, 0, 0, 0, 8'h24, 1'b1, "R8 ext true hit");
    evalOnce(5'h13, 0, 0, 0, 0, 8'h24, 1'b0, "R8 ext false hit");
    evalOnce(5'h12, 0, 0, 0, 0, 8'h25, 1'b0, "R8 ext true neighbour");
    evalOnce(5'h12, 0, 0, 0, 0, 8'h14, 1'b0, "R8 ext true other group");
    evalOnce(5'h12, 0, 0, 0, 0, 8'h3F, 1'b1, "R8 ext last line");
    evalOnce(5'h13, 0, 0, 0, 0, 8'h3E, 1'b1, "R8 ext false clear");
    extLines = '1;
    evalOnce(5'h12, 0, 0, 0, 0, 8'h44, 1'b0, "R9 out of range true");
    evalOnce(5'h13, 0, 0, 0, 0, 8'hF0, 1'b1, "R9 out of range false");
  endtask

  task automatic tReserved();
    extLines = '1;
    for (int c = 5'h14; c <= 5'h1F; c++) begin
      evalOnce(5'(c), 16'hFFFF, 16'hFFFF, 0, 0, 8'h00, 1'b0, "R10 reserved");
    end
  endtask

  task automatic tTiming();
    @(negedge clk);
    condCode = 5'h00; evalValid = 1'b0;
    @(negedge clk);
    check("R11 idle valid", takenValid, 1'b0);
    check("R11 idle taken", taken, 1'b0);
    evalOnce(5'h00, 0, 0, 0, 0, 0, 1'b1, "R11 single");
    @(negedge clk);
    check("R11 drop valid", takenValid, 1'b0);
    check("R11 drop taken", taken, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    tAlways();
    tAnd();
    tAllSet();
    tEqual();
    tSigned();
    tUnsigned();
    tField();
    tExt();
    tReserved();
    tTiming();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule